// File: doc/BRIEF.md
# Nonvolatile Store Access Controller

This block gives a processor one byte-wide control register through which it drives a small on-chip nonvolatile store. The store holds three banks: data, program and configuration. The store is modelled inside the block as byte arrays. A write into it takes a fixed, parameterised number of clocks. Two more byte registers sit beside the control register. One holds the target address. The other holds the byte to be written, or the byte returned by a read.

Software picks a bank with two select bits and arms writes with an enable bit. It then starts a single-clock read, a self-timed byte write, or an erase of an aligned 8-byte row by setting a start bit. Start bits can only be set from the bus. The hardware clears them when the operation ends. A warm reset that lands while a write is running aborts the write and latches an error flag. The bank select bits are left as they were, so the failed access can be traced. A power-on reset returns everything to a known state.

Top module: `nvm_ctl`

## Requirements
- R1: Power-on reset (`por` high at a clock edge) clears the control, address and data registers and every byte of all three banks to 0x00. It also drops `busy`.
- R2: Control bit 6 = 1 selects the configuration bank. Otherwise bit 7 = 1 selects the program bank, and bits 7,6 = 0,0 select the data bank. A write or read touches only the selected bank. Bit 5 always reads 0.
- R3: A control write starts a write cycle only if bit 1 and bit 2 (write enable) are both 1 in the written byte. If bit 2 = 0, bit 1 reads back 0 and `busy` stays low.
- R4: After a start, `busy` and control bit 1 are both 1 for exactly WR_CYCLES clocks. Then both fall, the addressed byte of the selected bank takes the data register value, and the error flag (bit 3) reads 0.
- R5: While `busy` is high, every bus write to the control, address or data register is ignored. This includes writing 0 to bit 1 and new start requests.
- R6: A control write with bit 0 = 1 and bit 7 = 0 (and no write start in the same byte) sets bit 0 for one clock. On the following edge, bit 0 clears and the data register takes the addressed byte of the selected bank.
- R7: A control write with bit 0 = 1 and bit 7 = 1 does not set bit 0 and leaves the data register unchanged.
- R8: If bit 4 is 1 when a write starts, the completed cycle sets all eight bytes of the row (address with its low three bits cleared) to 0xFF, and the data register value is not used.
- R9: A warm reset (`wrst` high) during a write cycle aborts it with no array change. It drops `busy`, sets bit 3, clears bits 4, 2, 1 and 0, and keeps bits 7 and 6 along with the address and data registers.
- R10: A warm reset while idle clears bits 4, 2, 1 and 0, and leaves bit 3 and bits 7, 6 unchanged.
- R11: Power-on reset clears bit 3 even when it is set.
- R12: `csr_sel` codes: 0 = control, 1 = address (low ADDR_W bits, upper bits read 0), 2 = data, 3 = reads 0x00 and ignores writes. `csr_rdata` follows `csr_sel` without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| wrst | input | 1 | Warm reset, synchronous, active high |
| csr_we | input | 1 | Register write strobe |
| csr_sel | input | 2 | Register select (0 control, 1 address, 2 data) |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read data, combinational |
| busy | output | 1 | High during a self-timed write or erase cycle |

## Verification
Register writes and start bits are visible at the first falling edge after the capturing rising edge. The bench drives inputs on falling edges and samples there. A read start shows bit 0 high at that falling edge, and the data register is checked one clock later. For a write or erase, the bench counts `busy` high at each of the next WR_CYCLES falling edges and expects it low on the following one. Array contents are then checked through later reads. A warm or power-on reset is checked at the falling edge right after the edge that applied it.

// File: rtl/nvm_pkg.sv
package nvm_pkg;

    // Control register image, bit 7 down to bit 0
    typedef struct packed {
        logic prog;   // 7: program bank select
        logic cfg;    // 6: configuration bank select
        logic rsvd;   // 5: always reads 0
        logic erase;  // 4: row erase on next write start
        logic err;    // 3: aborted write flag
        logic wen;    // 2: write enable
        logic wr;     // 1: write/erase start, hardware cleared
        logic rd;     // 0: read start, hardware cleared
    } nvm_ctl_t;

    typedef enum logic [1:0] {
        BANK_DATA = 2'd0,
        BANK_PROG = 2'd1,
        BANK_CFG  = 2'd2
    } nvm_bank_e;

    localparam int NUM_BANKS = 3;
    localparam int ROW_BYTES = 8;
    localparam int ROW_W     = $clog2(ROW_BYTES);
    localparam logic [7:0] ERASED = 8'hFF;

    localparam logic [1:0] CSR_CTL  = 2'd0;
    localparam logic [1:0] CSR_ADDR = 2'd1;
    localparam logic [1:0] CSR_DATA = 2'd2;

    // Configuration select wins over program select
    function automatic nvm_bank_e bank_of(input nvm_ctl_t c);
        if (c.cfg)       return BANK_CFG;
        else if (c.prog) return BANK_PROG;
        else             return BANK_DATA;
    endfunction

    function automatic logic [7:0] ctl_image(input nvm_ctl_t c);
        nvm_ctl_t v;
        v      = c;
        v.rsvd = 1'b0;
        return v;
    endfunction

endpackage

// File: rtl/nvm_store.sv
module nvm_store
    import nvm_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              por,
    input  logic              wr_en,
    input  logic              erase_en,
    input  nvm_bank_e         bank,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] bank_rd [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [7:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (por) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
            end else if (int'(bank) == b) begin
                if (wr_en) begin
                    mem[addr] <= wdata;
                end else if (erase_en) begin
                    for (int j = 0; j < ROW_BYTES; j++)
                        mem[{addr[ADDR_W-1:ROW_W], ROW_W'(j)}] <= ERASED;
                end
            end
        end

        assign bank_rd[b] = mem[addr];
    end

    always_comb begin
        rdata = 8'h00;
        for (int b = 0; b < NUM_BANKS; b++)
            if (int'(bank) == b) rdata = bank_rd[b];
    end

endmodule

// File: rtl/nvm_wr_timer.sv
module nvm_wr_timer #(
    parameter int WR_CYCLES = 16
) (
    input  logic clk,
    input  logic por,
    input  logic wrst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(WR_CYCLES + 1);

    logic          run_q;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (por || wrst) begin
            run_q  <= 1'b0;
            left_q <= '0;
        end else if (run_q) begin
            if (left_q == '0) run_q <= 1'b0;
            else              left_q <= left_q - 1'b1;
        end else if (start) begin
            run_q  <= 1'b1;
            left_q <= CW'(WR_CYCLES - 1);
        end
    end

    assign busy = run_q;
    assign done = run_q && (left_q == '0);

endmodule

// File: rtl/nvm_ctl_reg.sv
module nvm_ctl_reg
    import nvm_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              por,
    input  logic              wrst,
    input  logic              csr_we,
    input  logic [1:0]        csr_sel,
    input  logic [7:0]        csr_wdata,
    input  logic              busy,
    input  logic              done,
    input  logic [7:0]        rd_byte,
    output nvm_ctl_t          ctl_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [7:0]        data_q,
    output logic              start_wr
);
    nvm_ctl_t wv;
    logic     bus_ok;
    logic     ctl_acc;
    logic     start_rd;

    assign wv       = nvm_ctl_t'(csr_wdata);
    assign bus_ok   = csr_we && !busy;
    assign ctl_acc  = bus_ok && (csr_sel == CSR_CTL);
    assign start_wr = ctl_acc && wv.wr && wv.wen;
    assign start_rd = ctl_acc && wv.rd && !wv.prog && !start_wr;

    always_ff @(posedge clk) begin
        if (por) begin
            ctl_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (wrst) begin
            if (busy) ctl_q.err <= 1'b1;
            ctl_q.erase <= 1'b0;
            ctl_q.wen   <= 1'b0;
            ctl_q.wr    <= 1'b0;
            ctl_q.rd    <= 1'b0;
        end else begin
            if (ctl_q.rd) begin
                ctl_q.rd <= 1'b0;
                data_q   <= rd_byte;
            end
            if (done) begin
                ctl_q.wr  <= 1'b0;
                ctl_q.err <= 1'b0;
            end
            if (ctl_acc) begin
                ctl_q.prog  <= wv.prog;
                ctl_q.cfg   <= wv.cfg;
                ctl_q.erase <= wv.erase;
                ctl_q.err   <= wv.err;
                ctl_q.wen   <= wv.wen;
                if (start_wr) ctl_q.wr <= 1'b1;
                if (start_rd) ctl_q.rd <= 1'b1;
            end
            if (bus_ok && csr_sel == CSR_ADDR)
                addr_q <= csr_wdata[ADDR_W-1:0];
            if (bus_ok && csr_sel == CSR_DATA && !ctl_q.rd)
                data_q <= csr_wdata;
        end
    end

endmodule

// File: rtl/nvm_ctl.sv
module nvm_ctl
    import nvm_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int WR_CYCLES = 16
) (
    input  logic       clk,
    input  logic       por,
    input  logic       wrst,
    input  logic       csr_we,
    input  logic [1:0] csr_sel,
    input  logic [7:0] csr_wdata,
    output logic [7:0] csr_rdata,
    output logic       busy
);
    nvm_ctl_t          ctl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic [7:0]        rd_byte;
    logic              start_wr;
    logic              done;
    logic              commit;
    nvm_bank_e         bank;

    nvm_ctl_reg #(.ADDR_W(ADDR_W)) u_reg (
        .clk       (clk),
        .por       (por),
        .wrst      (wrst),
        .csr_we    (csr_we),
        .csr_sel   (csr_sel),
        .csr_wdata (csr_wdata),
        .busy      (busy),
        .done      (done),
        .rd_byte   (rd_byte),
        .ctl_q     (ctl_q),
        .addr_q    (addr_q),
        .data_q    (data_q),
        .start_wr  (start_wr)
    );

    nvm_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .por   (por),
        .wrst  (wrst),
        .start (start_wr),
        .busy  (busy),
        .done  (done)
    );

    assign bank   = bank_of(ctl_q);
    assign commit = done && !por && !wrst;

    nvm_store #(.ADDR_W(ADDR_W)) u_store (
        .clk      (clk),
        .por      (por),
        .wr_en    (commit && !ctl_q.erase),
        .erase_en (commit && ctl_q.erase),
        .bank     (bank),
        .addr     (addr_q),
        .wdata    (data_q),
        .rdata    (rd_byte)
    );

    always_comb begin
        csr_rdata = 8'h00;
        case (csr_sel)
            CSR_CTL:  csr_rdata = ctl_image(ctl_q);
            CSR_ADDR: csr_rdata[ADDR_W-1:0] = addr_q;
            CSR_DATA: csr_rdata = data_q;
            default:  csr_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/nvm_ctl_chk.sv
module nvm_ctl_chk #(
    parameter int WR_CYCLES = 16
) (
    input logic clk,
    input logic por,
    input logic wrst,
    input logic csr_we,
    input logic busy,
    input logic wr_bit,
    input logic rd_bit,
    input logic prog_bit,
    input logic cfg_bit,
    input logic err_bit
);
    int run_len;

    always_ff @(posedge clk) begin
        if (por)       run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    // R4
    wr_tracks_busy_chk: assert property (@(posedge clk) disable iff (por)
        wr_bit == busy);

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (por)
        busy |-> run_len < WR_CYCLES);

    // R4
    busy_full_chk: assert property (@(posedge clk) disable iff (por)
        ($fell(busy) && !$past(wrst)) |-> run_len == WR_CYCLES);

    // R6
    rd_one_cycle_chk: assert property (@(posedge clk) disable iff (por)
        (rd_bit && !csr_we) |=> !rd_bit);

    // R7
    rd_not_prog_chk: assert property (@(posedge clk) disable iff (por)
        $rose(rd_bit) |-> !prog_bit);

    // R9
    abort_err_chk: assert property (@(posedge clk) disable iff (por)
        (wrst && busy) |=> (err_bit && !busy));

    // R9
    abort_keep_sel_chk: assert property (@(posedge clk) disable iff (por)
        wrst |=> (prog_bit == $past(prog_bit) && cfg_bit == $past(cfg_bit)));

    // R10
    warm_err_keep_chk: assert property (@(posedge clk) disable iff (por)
        (wrst && !busy) |=> err_bit == $past(err_bit));

endmodule

bind nvm_ctl nvm_ctl_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
    .clk      (clk),
    .por      (por),
    .wrst     (wrst),
    .csr_we   (csr_we),
    .busy     (busy),
    .wr_bit   (ctl_q.wr),
    .rd_bit   (ctl_q.rd),
    .prog_bit (ctl_q.prog),
    .cfg_bit  (ctl_q.cfg),
    .err_bit  (ctl_q.err)
);

// File: tb/nvm_ctl_bench.sv
module nvm_ctl_bench;
    localparam int CLK_P = 10;
    localparam int WR_N  = 16;
    localparam int AW    = 6;

    logic       clk = 1'b0;
    logic       por, wrst, csr_we;
    logic [1:0] csr_sel;
    logic [7:0] csr_wdata;
    logic [7:0] csr_rdata;
    logic       busy;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] model [3][64];

    always #(CLK_P/2) clk = ~clk;

    nvm_ctl #(.ADDR_W(AW), .WR_CYCLES(WR_N)) u_nvm_ctl (
        .clk(clk), .por(por), .wrst(wrst), .csr_we(csr_we),
        .csr_sel(csr_sel), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .busy(busy)
    );

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int bank_idx(input logic [7:0] sel_bits);
        if (sel_bits[6])      return 2;
        else if (sel_bits[7]) return 1;
        else                  return 0;
    endfunction

    function automatic logic [7:0] row_base(input logic [7:0] a);
        return a & 8'h38;
    endfunction

    task automatic clear_model;
        for (int b = 0; b < 3; b++)
            for (int i = 0; i < 64; i++) model[b][i] = 8'h00;
    endtask

    task automatic csr_wr(input logic [1:0] s, input logic [7:0] v);
        csr_we = 1'b1; csr_sel = s; csr_wdata = v;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_rd(input logic [1:0] s, output logic [7:0] v);
        csr_sel = s;
        #1;
        v = csr_rdata;
    endtask

    task automatic pulse_wrst;
        wrst = 1'b1; @(negedge clk); wrst = 1'b0;
    endtask

    task automatic pulse_por;
        por = 1'b1; @(negedge clk); por = 1'b0;
        clear_model();
    endtask

    // write or erase with full busy window check
    task automatic do_write(input logic [7:0] sel_bits, input logic [7:0] a,
                            input logic [7:0] d, input bit erase, input logic [7:0] extra);
        int cnt = 0;
        logic [7:0] v;
        csr_wr(2'd1, a);
        csr_wr(2'd2, d);
        csr_wr(2'd0, sel_bits | 8'h06 | (erase ? 8'h10 : 8'h00) | extra);
        for (int i = 0; i < WR_N; i++) begin
            if (busy === 1'b1) cnt++;
            @(negedge clk);
        end
        chk("R4 busy cycles", cnt, WR_N);
        chk("R4 busy low after cycle", busy, 0);
        csr_rd(2'd0, v);
        chk("R4 control after cycle", v, sel_bits | 8'h04 | (erase ? 8'h10 : 8'h00));
        if (erase) begin
            for (int j = 0; j < 8; j++) model[bank_idx(sel_bits)][row_base(a) + j] = 8'hFF;
        end else begin
            model[bank_idx(sel_bits)][a[5:0]] = d;
        end
    endtask

    task automatic do_read(input logic [7:0] sel_bits, input logic [7:0] a, output logic [7:0] v);
        logic [7:0] c;
        csr_wr(2'd1, a);
        csr_wr(2'd0, sel_bits | 8'h01);
        csr_rd(2'd0, c);
        chk("R6 read start bit set", c[0], 1);
        @(negedge clk);
        csr_rd(2'd0, c);
        chk("R6 read start bit cleared", c[0], 0);
        csr_rd(2'd2, v);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'h5EED1234));
        por = 1'b1; wrst = 1'b0; csr_we = 1'b0; csr_sel = 2'd0; csr_wdata = 8'h00;
        clear_model();
        repeat (3) @(negedge clk);
        por = 1'b0;

        // R1 reset state
        csr_rd(2'd0, v); chk("R1 control reset", v, 8'h00);
        csr_rd(2'd1, v); chk("R1 address reset", v, 8'h00);
        csr_rd(2'd2, v); chk("R1 data reset", v, 8'h00);
        chk("R1 busy reset", busy, 0);

        // R2 bit 5 reads 0, R12 select codes
        csr_wr(2'd0, 8'h20);
        csr_rd(2'd0, v); chk("R2 bit5 reads 0", v, 8'h00);
        csr_wr(2'd3, 8'h5A);
        csr_rd(2'd3, v); chk("R12 select 3 reads 0", v, 8'h00);
        csr_wr(2'd1, 8'hFF);
        csr_rd(2'd1, v); chk("R12 address width", v, 8'h3F);

        // R3 start without write enable
        csr_wr(2'd0, 8'h02);
        csr_rd(2'd0, v); chk("R3 no start without enable", v, 8'h00);
        chk("R3 busy stays low", busy, 0);

        // R4 data bank write and readback
        do_write(8'h00, 8'd5, 8'hA5, 1'b0, 8'h00);
        do_read(8'h00, 8'd5, v); chk("R4 written byte", v, 8'hA5);

        // R5 writes ignored while busy
        csr_wr(2'd1, 8'd9);
        csr_wr(2'd2, 8'h3C);
        csr_wr(2'd0, 8'h06);
        csr_wr(2'd0, 8'h00);
        csr_wr(2'd1, 8'd17);
        csr_wr(2'd2, 8'h77);
        csr_rd(2'd0, v); chk("R5 control held", v, 8'h06);
        csr_rd(2'd1, v); chk("R5 address held", v, 8'd9);
        csr_rd(2'd2, v); chk("R5 data held", v, 8'h3C);
        model[0][9] = 8'h3C;
        repeat (WR_N) @(negedge clk);
        chk("R5 busy ends", busy, 0);
        do_read(8'h00, 8'd9, v); chk("R5 byte from original request", v, 8'h3C);

        // R7 read blocked with program bank selected
        csr_wr(2'd0, 8'h81);
        csr_rd(2'd0, v); chk("R7 read start refused", v, 8'h80);
        @(negedge clk);
        csr_rd(2'd2, v); chk("R7 data unchanged", v, 8'h3C);

        // R2 bank isolation
        do_write(8'h40, 8'd5, 8'h5A, 1'b0, 8'h00);
        do_write(8'h80, 8'd5, 8'h11, 1'b0, 8'h00);
        do_write(8'hC0, 8'd6, 8'h22, 1'b0, 8'h00);
        do_read(8'h00, 8'd5, v); chk("R2 data bank intact", v, 8'hA5);
        do_read(8'h40, 8'd5, v); chk("R2 config bank byte", v, 8'h5A);
        do_read(8'h40, 8'd6, v); chk("R2 config wins over program", v, 8'h22);

        // R8 row erase
        do_write(8'h00, 8'd16, 8'h44, 1'b0, 8'h00);
        do_write(8'h00, 8'd7, 8'h33, 1'b0, 8'h00);
        do_write(8'h00, 8'd13, 8'h00, 1'b1, 8'h00);
        do_read(8'h00, 8'd8, v);  chk("R8 row start erased", v, 8'hFF);
        do_read(8'h00, 8'd15, v); chk("R8 row end erased", v, 8'hFF);
        do_read(8'h00, 8'd16, v); chk("R8 next row kept", v, 8'h44);
        do_read(8'h00, 8'd7, v);  chk("R8 previous row kept", v, 8'h33);

        // R9 warm reset during a write
        csr_wr(2'd1, 8'd20);
        csr_wr(2'd2, 8'h99);
        csr_wr(2'd0, 8'h56);
        repeat (3) @(negedge clk);
        pulse_wrst();
        chk("R9 busy dropped", busy, 0);
        csr_rd(2'd0, v); chk("R9 control after abort", v, 8'h48);
        csr_rd(2'd1, v); chk("R9 address kept", v, 8'd20);
        csr_rd(2'd2, v); chk("R9 data kept", v, 8'h99);

        // R10 warm reset while idle keeps the error flag
        csr_wr(2'd0, 8'h5C);
        pulse_wrst();
        csr_rd(2'd0, v); chk("R10 idle warm reset", v, 8'h48);
        do_read(8'h40, 8'd20, v); chk("R9 aborted write left array", v, model[2][20]);

        // R4 normal completion clears the error flag
        do_write(8'h00, 8'd30, 8'h6E, 1'b0, 8'h08);

        // R11 power-on reset clears the error flag
        csr_wr(2'd0, 8'h08);
        csr_rd(2'd0, v); chk("R11 error flag set by software", v, 8'h08);
        pulse_por();
        csr_rd(2'd0, v); chk("R11 error flag cleared", v, 8'h00);
        do_read(8'h00, 8'd5, v); chk("R1 array cleared", v, 8'h00);

        // constrained random mix over data and config banks
        for (int it = 0; it < 60; it++) begin
            int op;
            logic [7:0] sb, a, d;
            op = $urandom_range(0, 2);
            sb = ($urandom_range(0, 1) == 1) ? 8'h40 : 8'h00;
            a  = 8'($urandom_range(0, 63));
            d  = 8'($urandom_range(0, 255));
            if (op == 2) begin
                do_read(sb, a, v);
                chk("R6 random read", v, model[bank_idx(sb)][a[5:0]]);
            end else begin
                do_write(sb, a, d, op == 1, 8'h00);
            end
        end

        finish_run();
    end

endmodule